// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Hardware RTS Release

This block serializes frames for a bit-oriented synchronous link, one bit per rising edge of the transmit clock. When the transmitter is enabled in synchronous frame mode and a byte is offered on its valid/ready input, it leaves the mark idle and sends an opening flag. It then sends each offered byte least significant bit first, inserting a zero after every run of five ones. When no byte is waiting at a byte boundary, the frame is closed. The default close is the complemented frame check sequence followed by a closing flag. An optional mode closes with the flag alone. After the close the line returns to continuous ones.

The active-low request-to-send pin normally mirrors a software control bit. In the automatic mode, software may clear that bit as soon as the last byte has been queued. The pin then stays asserted through the check sequence and the closing flag. Hardware releases it on the same transmit-clock edge at which the line returns to mark, so the line drivers can be turned around without waiting for software.

Top module: `sdlc_tx_rts`

## Requirements
- R1: During reset, txd is 1 (mark), rts_n is 1 and in_ready is 0.
- R2: A frame starts only from idle, and only when cfg_sdlc_mode, tx_enable and in_valid are all 1. The edge that starts it puts out one more mark bit. The following eight edges send the flag 0x7E, bit 0 first, with no zero insertion. Nothing starts while cfg_sdlc_mode or tx_enable is 0.
- R3: Data bytes are sent bit 0 first. After five consecutive 1s in the data and check-sequence bits, a 0 is inserted. The run count carries across byte boundaries and into the check sequence. A run that ends the stuffed region is also followed by a 0 before the closing flag.
- R4: in_ready is 1 only in the cycle that sends the last bit of the opening flag or of a data byte, and is 0 while idle. A byte is taken when in_valid and in_ready are both 1 at a rising edge.
- R5: If no byte is valid at a boundary while cfg_flag_on_underrun is 0, the frame is closed with a check sequence, a closing flag 0x7E and then mark. The check sequence is the ones' complement of the CRC over all data bits, sent bit 0 first, so the low byte goes out first. The CRC uses x^16+x^12+x^5+1, is preset to 0xFFFF at frame start, and takes the bits in line order.
- R6: If no byte is valid at a boundary while cfg_flag_on_underrun is 1, the closing flag follows the data directly and no check sequence is sent.
- R7: Automatic release is in effect only when cfg_auto_release is 1, cfg_sdlc_mode is 1 and cfg_flag_on_underrun is 0. Otherwise, and whenever no frame is in progress, rts_n equals the inverse of rts_bit one clock later.
- R8: With automatic release in effect, clearing rts_bit during a frame keeps rts_n at 0. The pin goes to 1 on the edge that ends the last closing-flag bit, which is the same edge at which txd goes from that final 0 to mark.
- R9: Setting rts_bit again before the closing flag has ended cancels the pending release. rts_n stays 0 after the frame ends.
- R10: Automatic release never asserts the pin by itself. If rts_bit is 0 when a frame starts, rts_n stays 1 for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sdlc_mode | input | 1 | Synchronous frame mode selected |
| cfg_auto_release | input | 1 | Enables hardware release of the RTS pin |
| cfg_flag_on_underrun | input | 1 | Close with flag only, no check sequence |
| tx_enable | input | 1 | Allows a new frame to start |
| rts_bit | input | 1 | Software request-to-send control |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | DATA_W | Byte to transmit |
| in_ready | output | 1 | Byte can be taken this cycle |
| txd | output | 1 | Serial line output |
| rts_n | output | 1 | Active-low request-to-send pin |

## Verification
Every result is registered once. The bit chosen at a rising edge appears on txd right after that edge, with the start edge itself still giving mark. An rts_bit change shows on rts_n one edge later, and the automatic release lands on the edge after the final closing-flag bit. The bench updates a behavioural line model and pin model at each rising edge. It compares txd and rts_n with them at the following falling edge, so every comparison looks at the value due one register after the inputs that caused it. in_ready is sampled at the falling edge before the edge it qualifies, which is the same edge the design uses to take the byte.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPEN  = 3'd1,
        ST_DATA  = 3'd2,
        ST_FCS   = 3'd3,
        ST_CLOSE = 3'd4
    } txs_e;

endpackage

// File: rtl/sdlc_fcs_acc.sv
module sdlc_fcs_acc #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h8408,
    parameter logic [CRC_W-1:0] INIT  = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q,
    output logic [CRC_W-1:0] crc_d
);

    // reflected shift: the line order is LSB first
    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = INIT;
        end else if (advance) begin
            crc_d = (crc_q >> 1) ^ (((crc_q[0] ^ bit_in) == 1'b1) ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/sdlc_framer.sv
module sdlc_framer
    import sdlc_tx_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                CRC_W     = 16,
    parameter int                STUFF_RUN = 5,
    parameter logic [DATA_W-1:0] FLAG_PAT  = 8'h7E,
    parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              flag_on_underrun,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [CRC_W-1:0]  crc_q,
    input  logic [CRC_W-1:0]  crc_d,
    output logic              crc_clear,
    output logic              crc_adv,
    output logic              crc_bit,
    output logic              txd,
    output logic              active
);

    localparam int BW = $clog2(DATA_W);
    localparam int CW = $clog2(CRC_W);
    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W - 1);
    localparam logic [CW-1:0] LAST_FCS  = CW'(CRC_W - 1);
    localparam logic [OW-1:0] RUN_MAX   = OW'(STUFF_RUN);

    typedef struct packed {
        txs_e              st;
        logic [CW-1:0]     cnt;
        logic [OW-1:0]     ones;
        logic [DATA_W-1:0] sh;
        logic [CRC_W-1:0]  fcs;
        logic              txd;
    } fr_t;

    localparam fr_t FR_RST = '{st: ST_IDLE, cnt: '0, ones: '0, sh: '0, fcs: '0, txd: 1'b1};

    fr_t  r_q, r_d;
    logic stuff_now;
    logic cur_bit;

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        crc_clear = 1'b0;
        crc_adv   = 1'b0;
        crc_bit   = 1'b0;
        cur_bit   = 1'b0;
        stuff_now = (r_q.ones == RUN_MAX) &&
                    ((r_q.st == ST_DATA) || (r_q.st == ST_FCS) || (r_q.st == ST_CLOSE));

        case (r_q.st)
            ST_IDLE: begin
                r_d.txd = 1'b1;
                if (start_ok && in_valid) begin
                    r_d.st    = ST_OPEN;
                    r_d.cnt   = '0;
                    r_d.ones  = '0;
                    crc_clear = 1'b1;
                end
            end

            ST_OPEN: begin
                r_d.txd = FLAG_PAT[r_q.cnt[BW-1:0]];
                if (r_q.cnt == LAST_DATA) begin
                    r_d.cnt  = '0;
                    r_d.ones = '0;
                    in_ready = 1'b1;
                    if (in_valid) begin
                        r_d.sh = in_data;
                        r_d.st = ST_DATA;
                    end else if (flag_on_underrun) begin
                        r_d.st = ST_CLOSE;
                    end else begin
                        r_d.st  = ST_FCS;
                        r_d.fcs = ~crc_d;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end

            ST_DATA: begin
                if (stuff_now) begin
                    r_d.txd  = 1'b0;
                    r_d.ones = '0;
                end else begin
                    cur_bit  = r_q.sh[r_q.cnt[BW-1:0]];
                    r_d.txd  = cur_bit;
                    crc_adv  = 1'b1;
                    crc_bit  = cur_bit;
                    r_d.ones = cur_bit ? (r_q.ones + OW'(1)) : '0;
                    if (r_q.cnt == LAST_DATA) begin
                        r_d.cnt  = '0;
                        in_ready = 1'b1;
                        if (in_valid) begin
                            r_d.sh = in_data;
                        end else if (flag_on_underrun) begin
                            r_d.st = ST_CLOSE;
                        end else begin
                            r_d.st  = ST_FCS;
                            r_d.fcs = ~crc_d;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
            end

            ST_FCS: begin
                if (stuff_now) begin
                    r_d.txd  = 1'b0;
                    r_d.ones = '0;
                end else begin
                    cur_bit  = r_q.fcs[0];
                    r_d.txd  = cur_bit;
                    r_d.fcs  = r_q.fcs >> 1;
                    r_d.ones = cur_bit ? (r_q.ones + OW'(1)) : '0;
                    if (r_q.cnt == LAST_FCS) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_CLOSE;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
            end

            ST_CLOSE: begin
                if (stuff_now) begin
                    r_d.txd  = 1'b0;
                    r_d.ones = '0;
                end else begin
                    r_d.txd  = FLAG_PAT[r_q.cnt[BW-1:0]];
                    r_d.ones = '0;
                    if (r_q.cnt == LAST_DATA) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end
            end

            default: begin
                r_d = FR_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= FR_RST;
        else        r_q <= r_d;
    end

    assign txd    = r_q.txd;
    assign active = (r_q.st != ST_IDLE);

    // R3: a run of ones is always broken before it reaches six
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ones <= RUN_MAX);

    // R2: two idle cycles in a row leave the line at mark
    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active)) |-> txd);

    // R4: an accepted byte is the one loaded for serialization
    p_accept_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (r_q.sh == $past(in_data)) && (r_q.st == ST_DATA));

    // R5: the check register is preset when a frame opens
    p_crc_preset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (crc_q == CRC_INIT));

    // R6: flag-only close never enters the check-sequence phase
    p_no_fcs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_on_underrun && (r_q.st == ST_DATA)) |=> (r_q.st != ST_FCS));

endmodule

// File: rtl/sdlc_rts_ctl.sv
module sdlc_rts_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_auto_release,
    input  logic cfg_sdlc_mode,
    input  logic cfg_flag_on_underrun,
    input  logic rts_bit,
    input  logic active,
    output logic rts_n
);

    logic auto_ok;
    logic rts_n_d, rts_n_q;

    assign auto_ok = cfg_auto_release && cfg_sdlc_mode && !cfg_flag_on_underrun;

    always_comb begin
        if (rts_bit) begin
            rts_n_d = 1'b0;
        end else if (auto_ok && active && !rts_n_q) begin
            rts_n_d = 1'b0;
        end else begin
            rts_n_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_n_q <= 1'b1;
        else        rts_n_q <= rts_n_d;
    end

    assign rts_n = rts_n_q;

    // R7: without the automatic mode the pin tracks the bit one clock later
    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_ok |=> (rts_n_q == !$past(rts_bit)));

    // R8: an asserted pin is held while the frame is still on the line
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_ok && active && !rts_n_q) |=> !rts_n_q);

    // R8: an automatic release only happens once the frame has ended
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n_q) && $past(auto_ok)) |-> !$past(active));

    // R9: the control bit always wins
    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rts_bit |=> !rts_n_q);

    // R10: a released pin is never asserted without the control bit
    p_no_self_assert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_n_q && !rts_bit) |=> rts_n_q);

endmodule

// File: rtl/sdlc_tx_rts.sv
module sdlc_tx_rts #(
    parameter int                DATA_W    = 8,
    parameter int                CRC_W     = 16,
    parameter logic [CRC_W-1:0]  CRC_POLY  = 16'h8408,
    parameter logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF,
    parameter int                STUFF_RUN = 5,
    parameter logic [DATA_W-1:0] FLAG_PAT  = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sdlc_mode,
    input  logic              cfg_auto_release,
    input  logic              cfg_flag_on_underrun,
    input  logic              tx_enable,
    input  logic              rts_bit,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              rts_n
);

    logic [CRC_W-1:0] crc_q, crc_d;
    logic             crc_clear, crc_adv, crc_bit;
    logic             frame_active;
    logic             start_ok;

    assign start_ok = cfg_sdlc_mode && tx_enable;

    sdlc_fcs_acc #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY),
        .INIT  (CRC_INIT)
    ) u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .advance (crc_adv),
        .bit_in  (crc_bit),
        .crc_q   (crc_q),
        .crc_d   (crc_d)
    );

    sdlc_framer #(
        .DATA_W    (DATA_W),
        .CRC_W     (CRC_W),
        .STUFF_RUN (STUFF_RUN),
        .FLAG_PAT  (FLAG_PAT),
        .CRC_INIT  (CRC_INIT)
    ) u_framer (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_ok         (start_ok),
        .flag_on_underrun (cfg_flag_on_underrun),
        .in_valid         (in_valid),
        .in_data          (in_data),
        .in_ready         (in_ready),
        .crc_q            (crc_q),
        .crc_d            (crc_d),
        .crc_clear        (crc_clear),
        .crc_adv          (crc_adv),
        .crc_bit          (crc_bit),
        .txd              (txd),
        .active           (frame_active)
    );

    sdlc_rts_ctl u_rts (
        .clk                  (clk),
        .rst_n                (rst_n),
        .cfg_auto_release     (cfg_auto_release),
        .cfg_sdlc_mode        (cfg_sdlc_mode),
        .cfg_flag_on_underrun (cfg_flag_on_underrun),
        .rts_bit              (rts_bit),
        .active               (frame_active),
        .rts_n                (rts_n)
    );

    // R8: the pin release and the return to mark share one edge
    p_release_with_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rts_n) && $past(cfg_auto_release && cfg_sdlc_mode && !cfg_flag_on_underrun)
         && $past(frame_active, 2)) |-> (txd && !$past(txd)));

endmodule

// File: tb/sdlc_tx_rts_bench.sv
module sdlc_tx_rts_bench;

    localparam logic [7:0] FLAG = 8'h7E;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cfg_sdlc_mode = 1'b1;
    logic       cfg_auto_release = 1'b0;
    logic       cfg_flag_on_underrun = 1'b0;
    logic       tx_enable = 1'b0;
    logic       rts_bit = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;
    logic       rts_n;

    sdlc_tx_rts u_sdlc_tx_rts (
        .clk                  (clk),
        .rst_n                (rst_n),
        .cfg_sdlc_mode        (cfg_sdlc_mode),
        .cfg_auto_release     (cfg_auto_release),
        .cfg_flag_on_underrun (cfg_flag_on_underrun),
        .tx_enable            (tx_enable),
        .rts_bit              (rts_bit),
        .in_valid             (in_valid),
        .in_data              (in_data),
        .in_ready             (in_ready),
        .txd                  (txd),
        .rts_n                (rts_n)
    );

    logic [7:0] src_q[$];
    bit         exp_bits[$];
    logic       exp_txd = 1'b1;
    logic       exp_rts = 1'b1;
    bit         m_active;
    bit         m_auto;
    int         checks = 0;
    int         fails = 0;
    int         taken = 0;
    int         releases = 0;
    string      txd_tag = "R2";
    string      rts_tag = "R7";
    bit         hs_pending = 1'b0;
    bit         chk_release = 1'b0;
    logic       prev_txd = 1'b1;
    logic       prev_rts = 1'b1;

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] crc_bit_step(input logic [15:0] c, input bit b);
        logic [15:0] s;
        s = {1'b0, c[15:1]};
        if ((c[0] ^ b) == 1'b1) s = s ^ 16'h8408;
        return s;
    endfunction

    // Expected line bits for a frame built from the bytes now queued
    function automatic void build_frame(input bit with_fcs);
        bit          raw[$];
        logic [15:0] crc;
        logic [15:0] fcs;
        logic [7:0]  byte_v;
        int          run;
        crc = 16'hFFFF;
        run = 0;
        exp_bits.delete();
        for (int i = 0; i < 8; i++) exp_bits.push_back(FLAG[i]);
        for (int k = 0; k < src_q.size(); k++) begin
            byte_v = src_q[k];
            for (int i = 0; i < 8; i++) begin
                raw.push_back(byte_v[i]);
                crc = crc_bit_step(crc, byte_v[i]);
            end
        end
        if (with_fcs) begin
            fcs = ~crc;
            for (int i = 0; i < 16; i++) raw.push_back(fcs[i]);
        end
        for (int i = 0; i < raw.size(); i++) begin
            exp_bits.push_back(raw[i]);
            if (raw[i]) run++;
            else        run = 0;
            if (run == 5) begin
                exp_bits.push_back(1'b0);
                run = 0;
            end
        end
        for (int i = 0; i < 8; i++) exp_bits.push_back(FLAG[i]);
    endfunction

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_bits.delete();
            exp_txd = 1'b1;
            exp_rts = 1'b1;
        end else begin
            m_active = (exp_bits.size() > 0);
            m_auto   = cfg_auto_release && cfg_sdlc_mode && !cfg_flag_on_underrun;
            if (rts_bit)                              exp_rts = 1'b0;
            else if (m_auto && m_active && !exp_rts)  exp_rts = 1'b0;
            else                                      exp_rts = 1'b1;
            if (m_active) begin
                exp_txd = exp_bits.pop_front();
            end else begin
                exp_txd = 1'b1;
                if (cfg_sdlc_mode && tx_enable && in_valid) build_frame(!cfg_flag_on_underrun);
            end
        end
    end

    // Compare and drive the byte stream away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(txd_tag, txd, exp_txd, "txd");
            check(rts_tag, rts_n, exp_rts, "rts_n");
            if (exp_bits.size() == 0) check("R4", in_ready, 1'b0, "in_ready while idle");
            if (chk_release && prev_rts === 1'b0 && rts_n === 1'b1) begin
                releases++;
                check("R8", prev_txd, 1'b0, "line bit before release");
                check("R8", txd, 1'b1, "line at release");
            end
            prev_txd = txd;
            prev_rts = rts_n;
            if (hs_pending) begin
                void'(src_q.pop_front());
                taken++;
            end
        end
        hs_pending = 1'b0;
        in_valid   = (src_q.size() > 0);
        in_data    = (src_q.size() > 0) ? src_q[0] : 8'h00;
        hs_pending = rst_n && in_valid && in_ready;
    end

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            if (exp_bits.size() == 0 && src_q.size() == 0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1", txd, 1'b1, "txd in reset");
        check("R1", rts_n, 1'b1, "rts_n in reset");
        check("R1", in_ready, 1'b0, "in_ready in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5 and R7: plain frame with check sequence, pin follows the bit
        txd_tag = "R5"; rts_tag = "R7";
        rts_bit = 1'b1; tx_enable = 1'b1;
        @(negedge clk);
        taken = 0;
        src_q.push_back(8'h12); src_q.push_back(8'h34); src_q.push_back(8'h56);
        wait_idle();
        check_int("R4", taken, 3, "bytes taken");
        rts_bit = 1'b0;
        repeat (3) @(negedge clk);

        // R3 and R8: stuffing-heavy frame, automatic release
        txd_tag = "R3"; rts_tag = "R8";
        cfg_auto_release = 1'b1; rts_bit = 1'b1;
        repeat (2) @(negedge clk);
        taken = 0; releases = 0;
        src_q.push_back(8'hFF); src_q.push_back(8'hFF);
        src_q.push_back(8'h7E); src_q.push_back(8'hF8);
        repeat (12) @(negedge clk);
        rts_bit = 1'b0; chk_release = 1'b1;
        wait_idle();
        chk_release = 1'b0;
        check_int("R8", releases, 1, "automatic releases");
        check_int("R4", taken, 4, "bytes taken");

        // R5: known text frame, automatic mode off
        txd_tag = "R5"; rts_tag = "R7";
        cfg_auto_release = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 9; i++) src_q.push_back(8'h31 + 8'(i));
        wait_idle();

        // R9: re-request before the frame ends
        txd_tag = "R5"; rts_tag = "R9";
        cfg_auto_release = 1'b1; rts_bit = 1'b1;
        repeat (2) @(negedge clk);
        src_q.push_back(8'hA5); src_q.push_back(8'h3C); src_q.push_back(8'h0F);
        repeat (10) @(negedge clk);
        rts_bit = 1'b0;
        repeat (10) @(negedge clk);
        rts_bit = 1'b1;
        wait_idle();
        check("R9", rts_n, 1'b0, "pin after cancelled release");
        rts_bit = 1'b0;
        repeat (3) @(negedge clk);

        // R6 and R7: flag-only close, automatic mode has no effect
        txd_tag = "R6"; rts_tag = "R7";
        cfg_flag_on_underrun = 1'b1; rts_bit = 1'b1;
        repeat (2) @(negedge clk);
        src_q.push_back(8'h81); src_q.push_back(8'hFF);
        repeat (8) @(negedge clk);
        rts_bit = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", rts_n, 1'b1, "pin with flag-only close");
        wait_idle();
        cfg_flag_on_underrun = 1'b0;
        repeat (2) @(negedge clk);

        // R10: frame sent with the control bit clear
        txd_tag = "R3"; rts_tag = "R10";
        src_q.push_back(8'h55); src_q.push_back(8'hAA);
        wait_idle();

        // R2: no start without frame mode or enable
        txd_tag = "R2"; rts_tag = "R7";
        cfg_sdlc_mode = 1'b0;
        src_q.push_back(8'hC3);
        repeat (20) @(negedge clk);
        check("R2", txd, 1'b1, "line with frame mode off");
        tx_enable = 1'b0; cfg_sdlc_mode = 1'b1;
        repeat (12) @(negedge clk);
        check("R2", txd, 1'b1, "line with enable off");
        check_int("R2", src_q.size(), 1, "byte left waiting");
        tx_enable = 1'b1;
        wait_idle();
        repeat (4) @(negedge clk);

        finish_run();
    end

endmodule